// File: doc/BRIEF.md
# Drive Status and Interrupt Unit

This block keeps the eight-bit status byte of a disk interface device and the flag that says an interrupt is waiting for the host. The drive controller feeds it single-cycle event strobes and a set of live condition levels. The block turns them into the busy, ready, write-fault, seek-complete, data-request, corrected, index and error bits, and into a raw interrupt request. Output enabling, address decoding and error-code generation sit in neighbouring logic.

The host sees the byte through two read strobes. A read of the primary status register acknowledges the interrupt. A read of the alternate status register returns the same byte and changes nothing. When a command ends with an error, the ready, write-fault and seek-complete bits keep the values they had at that moment. They stay that way until the host reads the primary status register, and after that read they follow the live drive conditions again.

Every output comes from a register. Each result is visible on the cycle after the clock edge that samples its cause.

Top module: `dsu_status_unit`

## Requirements
- R1: `status_o` bit 7 is BSY, bit 6 DRDY, bit 5 DWF, bit 4 DSC, bit 3 DRQ, bit 2 CORR, bit 1 IDX and bit 0 ERR. Neighbouring logic decodes this order.
- R2: After a synchronous reset, `status_o` is 8'h80 (only BSY set) and `irq_o` is 0.
- R3: BSY is 1 on the cycle after any cycle in which `srst_i`, `cmd_start_i` or `blk_done_i` is high. These causes take priority over a completion in the same cycle.
- R4: Take a cycle with `cmd_done_i` high and none of `srst_i`, `cmd_start_i` or `blk_done_i` high. On the next cycle BSY is 0, ERR equals the `cmd_err_i` of that cycle, and `irq_o` is 1. A command start clears ERR.
- R5: When the byte is not frozen, DRDY, DWF, DSC and DRQ show `ready_i`, `wfault_i`, `seek_ok_i` and `drq_i` as sampled on the previous clock edge.
- R6: A completion that has `cmd_err_i` high freezes DRDY, DWF and DSC at the live values of that cycle. They stay frozen until a cycle with `rd_status_i` high or `srst_i` high, and they track live values from the next edge on.
- R7: A primary status read clears `irq_o` on the next cycle. If a completion happens in the same cycle, `irq_o` stays 1.
- R8: An alternate status read changes neither `irq_o` nor the frozen state.
- R9: CORR is set by `corr_i` and stays set until a command start or `srst_i`. A start in the same cycle as `corr_i` leaves it clear.
- R10: IDX is 1 for exactly the cycle after each `index_i` pulse.
- R11: `srst_i` clears `irq_o`, ERR, CORR and the freeze on the next cycle. This overrides a completion in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| srst_i | input | 1 | Software reset level from the control register |
| cmd_start_i | input | 1 | Strobe: a command that raises BSY was written |
| blk_done_i | input | 1 | Strobe: one write block was transferred |
| cmd_done_i | input | 1 | Strobe: command completed |
| cmd_err_i | input | 1 | Error qualifier for `cmd_done_i` |
| ready_i | input | 1 | Live drive-ready condition |
| wfault_i | input | 1 | Live write-fault condition |
| seek_ok_i | input | 1 | Live seek-complete condition |
| drq_i | input | 1 | Live data-request condition |
| corr_i | input | 1 | Strobe: a corrected data error occurred |
| index_i | input | 1 | Strobe: index mark passed |
| rd_status_i | input | 1 | Host read of the primary status register |
| rd_altstat_i | input | 1 | Host read of the alternate status register |
| status_o | output | 8 | Status byte |
| irq_o | output | 1 | Raw pending interrupt request |

## Verification
Every result in this block is due exactly one edge after its cause. A strobe or read applied between two rising edges shows up on `status_o` and `irq_o` once the following edge has passed. The bench drives inputs and samples outputs on the falling edge. Its behavioural model advances on the rising edge with the same inputs the design saw, so each comparison lines up the model and the design over the same single-edge delay. The directed checks for freeze and acknowledge wait the same single cycle and then hold the stimulus for further cycles, to show that frozen bits do not drift.

// File: rtl/dsu_pkg.sv
package dsu_pkg;

    localparam int STAT_W = 8;
    localparam int COND_W = 3;

    typedef struct packed {
        logic bsy;
        logic drdy;
        logic dwf;
        logic dsc;
        logic drq;
        logic corr;
        logic idx;
        logic err;
    } stat_byte_t;

    typedef struct packed {
        logic drdy;
        logic dwf;
        logic dsc;
    } cond_t;

    typedef struct packed {
        logic srst;
        logic start;
        logic blk;
        logic done;
        logic err;
        logic corr;
        logic index;
    } evt_t;

    localparam stat_byte_t STAT_RESET = '{bsy: 1'b1, default: 1'b0};

    function automatic logic busy_next(input logic cur, input evt_t e);
        if (e.srst || e.start || e.blk) return 1'b1;
        if (e.done) return 1'b0;
        return cur;
    endfunction

    function automatic logic sticky_next(input logic cur, input logic set,
                                         input logic clr);
        if (clr) return 1'b0;
        if (set) return 1'b1;
        return cur;
    endfunction

endpackage

// File: rtl/dsu_busy.sv
module dsu_busy
    import dsu_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  evt_t ev,
    output logic bsy_o
);
    logic bsy_q;

    always_ff @(posedge clk) begin
        if (rst) bsy_q <= 1'b1;
        else     bsy_q <= busy_next(bsy_q, ev);
    end

    assign bsy_o = bsy_q;
endmodule

// File: rtl/dsu_cond_hold.sv
module dsu_cond_hold #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] live_i,
    input  logic         freeze_set_i,
    input  logic         release_i,
    output logic [W-1:0] held_o
);
    logic frozen_q;
    logic hold_now;

    assign hold_now = frozen_q && !release_i;

    always_ff @(posedge clk) begin
        if (rst)               frozen_q <= 1'b0;
        else if (freeze_set_i) frozen_q <= 1'b1;
        else if (release_i)    frozen_q <= 1'b0;
    end

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic bit_q;
        always_ff @(posedge clk) begin
            if (rst)            bit_q <= 1'b0;
            else if (!hold_now) bit_q <= live_i[i];
        end
        assign held_o[i] = bit_q;
    end
endmodule

// File: rtl/dsu_flags.sv
module dsu_flags
    import dsu_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  evt_t ev,
    input  logic drq_i,
    output logic drq_o,
    output logic corr_o,
    output logic idx_o,
    output logic err_o
);
    logic drq_q, corr_q, idx_q, err_q;
    logic clr_cmd;

    assign clr_cmd = ev.srst || ev.start;

    always_ff @(posedge clk) begin
        if (rst) begin
            drq_q  <= 1'b0;
            corr_q <= 1'b0;
            idx_q  <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            drq_q  <= drq_i;
            idx_q  <= ev.index;
            corr_q <= sticky_next(corr_q, ev.corr, clr_cmd);
            if (clr_cmd)      err_q <= 1'b0;
            else if (ev.done) err_q <= ev.err;
        end
    end

    assign drq_o  = drq_q;
    assign corr_o = corr_q;
    assign idx_o  = idx_q;
    assign err_o  = err_q;
endmodule

// File: rtl/dsu_irq.sv
module dsu_irq (
    input  logic clk,
    input  logic rst,
    input  logic srst_i,
    input  logic raise_i,
    input  logic ack_i,
    output logic irq_o
);
    logic pend_q;

    always_ff @(posedge clk) begin
        if (rst || srst_i) pend_q <= 1'b0;
        else if (raise_i)  pend_q <= 1'b1;
        else if (ack_i)    pend_q <= 1'b0;
    end

    assign irq_o = pend_q;
endmodule

// File: rtl/dsu_status_unit.sv
module dsu_status_unit
    import dsu_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       srst_i,
    input  logic       cmd_start_i,
    input  logic       blk_done_i,
    input  logic       cmd_done_i,
    input  logic       cmd_err_i,
    input  logic       ready_i,
    input  logic       wfault_i,
    input  logic       seek_ok_i,
    input  logic       drq_i,
    input  logic       corr_i,
    input  logic       index_i,
    input  logic       rd_status_i,
    input  logic       rd_altstat_i,
    output logic [7:0] status_o,
    output logic       irq_o
);
    evt_t       ev;
    cond_t      live, held;
    stat_byte_t sb;
    logic       bsy, drq, corr, idx, err;
    logic       freeze_set, release_hold;

    assign ev = '{srst: srst_i, start: cmd_start_i, blk: blk_done_i,
                  done: cmd_done_i, err: cmd_err_i, corr: corr_i,
                  index: index_i};

    assign live = '{drdy: ready_i, dwf: wfault_i, dsc: seek_ok_i};

    // The alternate read is only a data path; it does not reach any state.
    assign freeze_set   = cmd_done_i && cmd_err_i && !srst_i;
    assign release_hold = rd_status_i || srst_i;

    dsu_busy u_busy (
        .clk   (clk),
        .rst   (rst),
        .ev    (ev),
        .bsy_o (bsy)
    );

    dsu_cond_hold #(.W(COND_W)) u_hold (
        .clk          (clk),
        .rst          (rst),
        .live_i       (live),
        .freeze_set_i (freeze_set),
        .release_i    (release_hold),
        .held_o       (held)
    );

    dsu_flags u_flags (
        .clk    (clk),
        .rst    (rst),
        .ev     (ev),
        .drq_i  (drq_i),
        .drq_o  (drq),
        .corr_o (corr),
        .idx_o  (idx),
        .err_o  (err)
    );

    dsu_irq u_irq (
        .clk     (clk),
        .rst     (rst),
        .srst_i  (srst_i),
        .raise_i (cmd_done_i),
        .ack_i   (rd_status_i),
        .irq_o   (irq_o)
    );

    assign sb = '{bsy: bsy, drdy: held.drdy, dwf: held.dwf, dsc: held.dsc,
                  drq: drq, corr: corr, idx: idx, err: err};

    assign status_o = sb;
endmodule

// File: rtl/dsu_status_unit_chk.sv
module dsu_status_unit_chk (
    input logic       clk,
    input logic       rst,
    input logic       srst_i,
    input logic       cmd_start_i,
    input logic       blk_done_i,
    input logic       cmd_done_i,
    input logic       cmd_err_i,
    input logic       index_i,
    input logic       rd_status_i,
    input logic       rd_altstat_i,
    input logic [7:0] status_o,
    input logic       irq_o
);
    logic frz_m;

    always_ff @(posedge clk) begin
        if (rst || srst_i)                  frz_m <= 1'b0;
        else if (cmd_done_i && cmd_err_i)   frz_m <= 1'b1;
        else if (rd_status_i)               frz_m <= 1'b0;
    end

    assert_bsy_set_R3: assert property (@(posedge clk) disable iff (rst)
        (srst_i || cmd_start_i || blk_done_i) |=> status_o[7]);

    assert_done_R4: assert property (@(posedge clk) disable iff (rst)
        (cmd_done_i && !srst_i && !cmd_start_i && !blk_done_i)
        |=> (!status_o[7] && irq_o && status_o[0] == $past(cmd_err_i)));

    assert_freeze_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (frz_m && !rd_status_i && !srst_i) |=> $stable(status_o[6:4]));

    assert_ack_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_status_i && !cmd_done_i) |=> !irq_o);

    assert_alt_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        (rd_altstat_i && !rd_status_i && !cmd_done_i && !srst_i)
        |=> irq_o == $past(irq_o));

    assert_index_R10: assert property (@(posedge clk) disable iff (rst)
        index_i |=> status_o[1]);

    assert_srst_R11: assert property (@(posedge clk) disable iff (rst)
        srst_i |=> (!irq_o && !status_o[0] && !status_o[2]));
endmodule

bind dsu_status_unit dsu_status_unit_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .srst_i       (srst_i),
    .cmd_start_i  (cmd_start_i),
    .blk_done_i   (blk_done_i),
    .cmd_done_i   (cmd_done_i),
    .cmd_err_i    (cmd_err_i),
    .index_i      (index_i),
    .rd_status_i  (rd_status_i),
    .rd_altstat_i (rd_altstat_i),
    .status_o     (status_o),
    .irq_o        (irq_o)
);

// File: tb/sim_dsu_status_unit.sv
`timescale 1ns/1ps
module sim_dsu_status_unit;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic srst_i = 0, cmd_start_i = 0, blk_done_i = 0, cmd_done_i = 0;
    logic cmd_err_i = 0, ready_i = 0, wfault_i = 0, seek_ok_i = 0;
    logic drq_i = 0, corr_i = 0, index_i = 0;
    logic rd_status_i = 0, rd_altstat_i = 0;
    logic [7:0] status_o;
    logic irq_o;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done_run = 0;
    bit model_on = 0;

    // behavioural model state
    int m_bsy = 1, m_rdy = 0, m_wf = 0, m_sk = 0, m_drq = 0;
    int m_corr = 0, m_idx = 0, m_err = 0, m_irq = 0, m_frz = 0;

    always #2.5 clk = ~clk;

    dsu_status_unit u0 (
        .clk(clk), .rst(rst), .srst_i(srst_i), .cmd_start_i(cmd_start_i),
        .blk_done_i(blk_done_i), .cmd_done_i(cmd_done_i), .cmd_err_i(cmd_err_i),
        .ready_i(ready_i), .wfault_i(wfault_i), .seek_ok_i(seek_ok_i),
        .drq_i(drq_i), .corr_i(corr_i), .index_i(index_i),
        .rd_status_i(rd_status_i), .rd_altstat_i(rd_altstat_i),
        .status_o(status_o), .irq_o(irq_o)
    );

    task automatic chk(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, got, exp, cycles);
        end
    endtask

    // Reference model, advanced on each rising edge from the inputs seen there.
    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            m_bsy = 1; m_rdy = 0; m_wf = 0; m_sk = 0; m_drq = 0;
            m_corr = 0; m_idx = 0; m_err = 0; m_irq = 0; m_frz = 0;
            model_on = 1;
        end else begin
            int hold;
            hold = (m_frz != 0) && !rd_status_i && !srst_i;
            if (!hold) begin m_rdy = ready_i; m_wf = wfault_i; m_sk = seek_ok_i; end
            m_drq = drq_i;
            m_idx = index_i;
            if (srst_i || cmd_start_i) begin m_err = 0; m_corr = 0; end
            else begin
                if (cmd_done_i) m_err = cmd_err_i;
                if (corr_i) m_corr = 1;
            end
            if (srst_i || cmd_start_i || blk_done_i) m_bsy = 1;
            else if (cmd_done_i) m_bsy = 0;
            if (srst_i) m_irq = 0;
            else if (cmd_done_i) m_irq = 1;
            else if (rd_status_i) m_irq = 0;
            if (srst_i) m_frz = 0;
            else if (cmd_done_i && cmd_err_i) m_frz = 1;
            else if (rd_status_i) m_frz = 0;
        end
    end

    // Per-cycle comparison, one check per field, tagged with its requirement.
    always @(negedge clk) begin
        if (model_on && !done_run) begin
            chk("R3 BSY", status_o[7], m_bsy);
            chk("R6 DRDY", status_o[6], m_rdy);
            chk("R6 DWF", status_o[5], m_wf);
            chk("R6 DSC", status_o[4], m_sk);
            chk("R5 DRQ", status_o[3], m_drq);
            chk("R9 CORR", status_o[2], m_corr);
            chk("R10 IDX", status_o[1], m_idx);
            chk("R4 ERR", status_o[0], m_err);
            chk("R7 IRQ", irq_o, m_irq);
        end
    end

    task automatic clr_strobes();
        cmd_start_i = 0; blk_done_i = 0; cmd_done_i = 0; cmd_err_i = 0;
        corr_i = 0; index_i = 0; rd_status_i = 0; rd_altstat_i = 0;
    endtask

    task automatic nxt();
        @(negedge clk);
        #0.5;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done_run) begin
            checks++; failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            done_run = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) nxt();
        chk("R2 reset status", status_o, 8'h80);
        chk("R2 reset irq", irq_o, 0);
        rst = 0;
        nxt();
        chk("R2 after release", status_o, 8'h80);

        // R1: known pattern through a failing completion
        ready_i = 1; seek_ok_i = 1; drq_i = 1;
        cmd_done_i = 1; cmd_err_i = 1; corr_i = 1; index_i = 1;
        nxt(); clr_strobes();
        chk("R1 bit order", status_o, 8'h5F);
        chk("R4 irq raised", irq_o, 1);

        // R6: live drops must not show while frozen
        ready_i = 0; seek_ok_i = 0; wfault_i = 1;
        nxt(); nxt();
        chk("R6 frozen byte", status_o[6:4], 3'b101);
        // R8: alternate read changes nothing
        rd_altstat_i = 1;
        nxt(); clr_strobes();
        chk("R8 irq kept", irq_o, 1);
        nxt();
        chk("R8 still frozen", status_o[6:4], 3'b101);
        // R7 / R6: primary read acknowledges and releases
        rd_status_i = 1;
        nxt(); clr_strobes();
        chk("R7 irq cleared", irq_o, 0);
        chk("R6 released live", status_o[6:4], 3'b010);

        // R7: read coinciding with completion keeps irq
        cmd_done_i = 1; rd_status_i = 1;
        nxt(); clr_strobes();
        chk("R7 same-cycle raise", irq_o, 1);
        chk("R4 clean done ERR", status_o[0], 0);

        // R3 / R9: start clears CORR, sets BSY
        cmd_start_i = 1;
        nxt(); clr_strobes();
        chk("R3 start BSY", status_o[7], 1);
        chk("R9 CORR cleared", status_o[2], 0);
        corr_i = 1;
        nxt(); clr_strobes();
        nxt();
        chk("R9 CORR sticky", status_o[2], 1);
        chk("R10 IDX gone", status_o[1], 0);

        // R11: software reset beats completion
        cmd_done_i = 1; cmd_err_i = 1; srst_i = 1;
        nxt(); clr_strobes();
        chk("R11 irq", irq_o, 0);
        chk("R11 err corr bsy", {status_o[7], status_o[2], status_o[0]}, 3'b100);
        srst_i = 0;
        nxt();

        // Mixed random phase, compared every cycle by the model
        for (int i = 0; i < 4000; i++) begin
            srst_i       = ($urandom_range(0, 40) == 0);
            cmd_start_i  = ($urandom_range(0, 9) == 0);
            blk_done_i   = ($urandom_range(0, 11) == 0);
            cmd_done_i   = ($urandom_range(0, 6) == 0);
            cmd_err_i    = ($urandom_range(0, 2) == 0);
            corr_i       = ($urandom_range(0, 9) == 0);
            index_i      = ($urandom_range(0, 7) == 0);
            rd_status_i  = ($urandom_range(0, 5) == 0);
            rd_altstat_i = ($urandom_range(0, 4) == 0);
            if ($urandom_range(0, 3) == 0) begin
                ready_i   = $urandom_range(0, 1);
                wfault_i  = $urandom_range(0, 1);
                seek_ok_i = $urandom_range(0, 1);
                drq_i     = $urandom_range(0, 1);
            end
            nxt();
        end
        clr_strobes(); srst_i = 0;
        nxt();
        done_run = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule